// File: doc/BRIEF.md
# Bus Mastership Requester

This block is the requesting side of a shared operand bus that is handed between masters through a request, grant and acknowledge exchange. A free-running clock drives a four-phase bus-cycle counter (phases C1 to C4). When the core raises its need for the bus, the block asserts a bus request as the next C2 phase begins. While the request is up, it looks at the arbiter's grant (active low) and busy (active high) lines on every falling clock edge.

Mastership is won only when one falling-edge sample shows grant low and busy high together. The block then waits for the next C3 phase boundary. There it drops the request and asserts the acknowledge line, which keeps other masters off the bus. It also tells the core that it owns the bus. When the core no longer needs the bus, acknowledge is released, again at a C3 phase boundary. The arbiter, the bus data paths and the core are outside the block.

Top module: `busreq_top`

## Requirements
- R1: The phase output counts 0 (C1), 1 (C2), 2 (C3), 3 (C4) and wraps back to 0. It advances one step per rising clock edge, and a synchronous reset sets it to 0.
- R2: When need is high on the rising edge that moves the phase from C1 to C2, request rises on that edge. Request then stays high until mastership is taken, even if need drops in the meantime.
- R3: Grant and busy are looked at only on falling clock edges and only while request is high. A sample with grant low and busy high marks the bus as won.
- R4: A sample with grant high, or with busy low, does not win the bus. Request stays high and the block keeps waiting.
- R5: After a winning sample, acknowledge rises and request falls on the first rising edge that moves the phase from C2 to C3.
- R6: Acknowledge stays high while need is high. It falls on the first rising edge that moves the phase from C2 to C3 with need low.
- R7: The owned output is high exactly when acknowledge is high.
- R8: Reset clears request, acknowledge and owned.
- R9: Request is not raised again while the bus is owned, and request and acknowledge are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; phase steps on rising edges, grant and busy are sampled on falling edges |
| rst | input | 1 | Synchronous active-high reset |
| need_i | input | 1 | Core wants the bus |
| grant_n_i | input | 1 | Arbiter grant, active low |
| busy_i | input | 1 | Bus free indication, active high |
| phase_o | output | 2 | Current bus-cycle phase, 0..3 for C1..C4 |
| req_o | output | 1 | Bus request to the arbiter |
| ack_o | output | 1 | Mastership acknowledge, locks out other masters |
| owned_o | output | 1 | Core-side indication that the bus is held |

## Verification
Most internal faults in this block appear at the ports within one bus cycle of four clocks. A wrong phase count changes phase_o on the very next edge. A lost or false winning sample shows up at the next C2-to-C3 boundary: either acknowledge rises with no valid grant/busy pair, or request stays high past the point where it should have handed over. A controller stuck in the wrong state shows up at the following C3 boundary as an acknowledge that does not release, or as a request raised while the bus is held. The bench compares all four outputs every cycle against a model built from the requirements.

// File: rtl/busreq_pkg.sv
package busreq_pkg;

    // Bus-cycle phases, one per rising clock edge
    typedef enum logic [1:0] {
        PH_C1 = 2'd0,
        PH_C2 = 2'd1,
        PH_C3 = 2'd2,
        PH_C4 = 2'd3
    } phase_e;

    // Mastership controller states
    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_ASK  = 2'd1,
        MS_HOLD = 2'd2
    } mstate_e;

    // Arbiter lines as seen by the requester
    typedef struct packed {
        logic grant_n;
        logic busy;
    } bus_sense_t;

    // Controller outputs bundled
    typedef struct packed {
        logic req;
        logic ack;
        logic owned;
    } ms_out_t;

    // Phase during which the controller decides to raise request (edge leaves it)
    localparam phase_e PH_BEFORE_REQ = PH_C1;
    // Phase whose ending edge starts C3: acknowledge changes there
    localparam phase_e PH_BEFORE_ACK = PH_C2;

    function automatic phase_e phase_succ(input phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

    function automatic logic sense_wins(input bus_sense_t s);
        return (!s.grant_n) && s.busy;
    endfunction

endpackage

// File: rtl/busreq_phase_gen.sv
module busreq_phase_gen
    import busreq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase_o
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_C1;
        end else begin
            phase_q <= phase_succ(phase_q);
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/busreq_grant_sampler.sv
module busreq_grant_sampler
    import busreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       armed_i,
    input  bus_sense_t sense_i,
    output logic       win_o
);

    logic win_q;

    // Falling-edge sampling; the win flag is sticky while armed
    always_ff @(negedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
        end else if (!armed_i) begin
            win_q <= 1'b0;
        end else if (sense_wins(sense_i)) begin
            win_q <= 1'b1;
        end
    end

    assign win_o = win_q;

endmodule

// File: rtl/busreq_ctrl.sv
module busreq_ctrl
    import busreq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    need_i,
    input  phase_e  phase_i,
    input  logic    win_i,
    output ms_out_t out_o
);

    mstate_e st_q;
    logic    req_q;
    logic    ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= MS_IDLE;
            req_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            unique case (st_q)
                MS_IDLE: begin
                    if (need_i && (phase_i == PH_BEFORE_REQ)) begin
                        st_q  <= MS_ASK;
                        req_q <= 1'b1;
                    end
                end
                MS_ASK: begin
                    if (win_i && (phase_i == PH_BEFORE_ACK)) begin
                        st_q  <= MS_HOLD;
                        req_q <= 1'b0;
                        ack_q <= 1'b1;
                    end
                end
                MS_HOLD: begin
                    if (!need_i && (phase_i == PH_BEFORE_ACK)) begin
                        st_q  <= MS_IDLE;
                        ack_q <= 1'b0;
                    end
                end
                default: begin
                    st_q  <= MS_IDLE;
                    req_q <= 1'b0;
                    ack_q <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        out_o.req   = req_q;
        out_o.ack   = ack_q;
        out_o.owned = (st_q == MS_HOLD);
    end

endmodule

// File: rtl/busreq_top.sv
module busreq_top
    import busreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       need_i,
    input  logic       grant_n_i,
    input  logic       busy_i,
    output logic [1:0] phase_o,
    output logic       req_o,
    output logic       ack_o,
    output logic       owned_o
);

    phase_e     phase_w;
    bus_sense_t sense_w;
    logic       win_w;
    ms_out_t    ms_w;

    assign sense_w.grant_n = grant_n_i;
    assign sense_w.busy    = busy_i;

    busreq_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase_w)
    );

    busreq_grant_sampler u_sampler (
        .clk     (clk),
        .rst     (rst),
        .armed_i (ms_w.req),
        .sense_i (sense_w),
        .win_o   (win_w)
    );

    busreq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .need_i  (need_i),
        .phase_i (phase_w),
        .win_i   (win_w),
        .out_o   (ms_w)
    );

    assign phase_o = phase_w;
    assign req_o   = ms_w.req;
    assign ack_o   = ms_w.ack;
    assign owned_o = ms_w.owned;

endmodule

// File: rtl/busreq_checker.sv
module busreq_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase,
    input logic       req,
    input logic       ack,
    input logic       owned,
    input logic       win
);

    logic prim_q = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) prim_q <= 1'b1;
    end

    // R1: phase steps by one each edge outside reset
    a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
        (prim_q && !$past(rst)) |-> (phase == 2'($past(phase) + 2'd1)));

    // R2: request rises only entering C2
    a_r2_req_rise_c2: assert property (@(posedge clk) disable iff (rst)
        (prim_q && $rose(req)) |-> (phase == 2'd1));

    // R3: acknowledge rises only after a winning sample
    a_r3_ack_needs_win: assert property (@(posedge clk) disable iff (rst)
        (prim_q && $rose(ack)) |-> $past(win));

    // R3: win flag only exists while request is up
    a_r3_win_implies_req: assert property (@(posedge clk) disable iff (rst)
        prim_q |-> (!win || req));

    // R5: acknowledge rises entering C3
    a_r5_ack_rise_c3: assert property (@(posedge clk) disable iff (rst)
        (prim_q && $rose(ack)) |-> (phase == 2'd2));

    // R6: acknowledge falls entering C3
    a_r6_ack_fall_c3: assert property (@(posedge clk) disable iff (rst)
        (prim_q && $fell(ack)) |-> (phase == 2'd2));

    // R7: owned tracks acknowledge
    a_r7_owned_ack: assert property (@(posedge clk) disable iff (rst)
        prim_q |-> (owned == ack));

    // R9: request and acknowledge never overlap
    a_r9_no_req_ack: assert property (@(posedge clk) disable iff (rst)
        prim_q |-> !(req && ack));

endmodule

bind busreq_top busreq_checker chk_i (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_o),
    .req   (req_o),
    .ack   (ack_o),
    .owned (owned_o),
    .win   (win_w)
);

// File: tb/busreq_top_tb_top.sv
module busreq_top_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       need = 1'b0;
    logic       gn = 1'b1;
    logic       busy = 1'b0;
    logic [1:0] phase;
    logic       req, ack, owned;

    busreq_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .need_i    (need),
        .grant_n_i (gn),
        .busy_i    (busy),
        .phase_o   (phase),
        .req_o     (req),
        .ack_o     (ack),
        .owned_o   (owned)
    );

    typedef struct packed {
        logic [1:0] ph;
        logic       req;
        logic       ack;
        logic       owned;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;

    // Reference model state
    int m_ph = 0;
    bit m_req = 0, m_ack = 0, m_win = 0;
    int m_st = 0;

    task automatic step(input bit r, input bit n, input bit g, input bit b, input string tag);
        exp_t e;
        @(posedge clk);
        #5;
        rst = r; need = n; gn = g; busy = b;
        // falling-edge sample (R3, R4)
        if (r || !m_req) m_win = 0;
        else if (!g && b) m_win = 1;
        // next rising edge
        if (r) begin
            m_ph = 0; m_req = 0; m_ack = 0; m_st = 0;
        end else begin
            case (m_st)
                0: if (n && m_ph == 0) begin m_st = 1; m_req = 1; end
                1: if (m_win && m_ph == 1) begin m_st = 2; m_req = 0; m_ack = 1; end
                default: if (!n && m_ph == 1) begin m_st = 0; m_ack = 0; end
            endcase
            m_ph = (m_ph + 1) % 4;
        end
        e.ph = 2'(m_ph); e.req = m_req; e.ack = m_ack; e.owned = m_ack;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic chk(input string tag, input string rq, input int act, input int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s/%s actual=%0d expected=%0d at %0t", tag, rq, act, expv, $time);
        end
    endtask

    // Monitor: pops expected items and compares
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "R1 phase", int'(phase), int'(e.ph));
                chk(t, "R2 req",   int'(req),   int'(e.req));
                chk(t, "R5 ack",   int'(ack),   int'(e.ack));
                chk(t, "R7 owned", int'(owned), int'(e.owned));
            end
        end
    end

    initial begin
        logic [7:0] lf;
        lf = 8'hA5;
        // R8: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, "R8");
        // R3: grant/busy ignored with no request
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, "R3");
        // R4: waiting with grant high, then grant low but busy low
        for (int i = 0; i < 10; i++) step(0, 1, 1, 1, "R4");
        for (int i = 0; i < 9; i++) step(0, 1, 0, 0, "R4");
        // R5: winning sample, then R9 hold with need high
        for (int i = 0; i < 14; i++) step(0, 1, 0, 1, "R5");
        for (int i = 0; i < 6; i++) step(0, 1, 1, 0, "R9");
        // R6: release
        for (int i = 0; i < 9; i++) step(0, 0, 1, 0, "R6");
        // R2: need dropped while asking keeps request
        step(0, 1, 1, 1, "R2");
        step(0, 1, 1, 1, "R2");
        for (int i = 0; i < 10; i++) step(0, 0, 1, 1, "R2");
        for (int i = 0; i < 6; i++) step(0, 1, 0, 1, "R2");
        // R8: reset while owning
        step(1, 1, 0, 1, "R8");
        step(1, 1, 0, 1, "R8");
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, "R8");
        // R3: single-cycle winning pulses at mixed phases
        for (int i = 0; i < 40; i++) step(0, 1, (i % 7) != 3, 1, "R3");
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, "R6");
        // Mixed pattern
        for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(0, ((i / 23) % 3) != 0, lf[0], lf[2] | lf[5], "R3");
        end
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule